// File: doc/BRIEF.md
# Per-Block Lock and Write-Protect Controller

This block decides, for a flash-style array of independently erasable blocks, whether a requested program or erase may proceed. Each block carries a lock bit and a small set of sticky flags. A global byte reports readiness and an accumulated failure flag. The lock bits are enforced only while the active-low write-protect input is driven low. With that input high, every block may be written whatever its lock bit says.

A request names one operation and one block index. Program and erase are judged at once, and the verdict appears as a one-cycle `grant_o` or `deny_o` pulse on the following cycle. Lock sets one lock bit. Unlock-all clears every lock bit, and only when write protection is released. Erase-all starts a sequencer that visits the blocks in ascending order, one per cycle. It grants every block that is not protected and marks each protected block as skipped. A clear-status strobe wipes the flags but leaves the locks alone. The asynchronous reset aborts the sequencer and clears every register.

Top module: `blk_lock_ctrl`

## Requirements
- R1: After reset, `grant_o`, `deny_o` and `busy_o` are 0, every block status byte reads 0x00 and the global byte reads 0x80.
- R2: Block status byte layout: bit 6 lock, bit 5 failed, bit 4 skipped by erase-all, bit 2 granted-operation marker, all other bits 0. Global byte layout: bit 7 ready (not busy), bit 5 failed since last clear, all other bits 0.
- R3: With `wp_ni` low, a program (op 0) or erase (op 1) to a locked block gives `deny_o`=1 and `grant_o`=0 in the next cycle. It sets that block's bit 5 and global bit 5.
- R4: A program or erase to an unlocked block, or to any block while `wp_ni` is high, gives `grant_o`=1 and `grant_blk_o` equal to the block in the next cycle, and sets that block's bit 2.
- R5: Lock (op 3) sets bit 6 of the addressed block whatever the level of `wp_ni`, and pulses neither `grant_o` nor `deny_o`.
- R6: `clr_status_i` clears global bit 5 and bits 5, 4 and 2 of every block, and leaves every lock bit unchanged.
- R7: A flag set by an event in the same cycle as `clr_status_i` ends up set.
- R8: Unlock-all (op 4) clears every lock bit when `wp_ni` is high. When `wp_ni` is low it changes no lock bit, pulses `deny_o` and sets global bit 5.
- R9: Erase-all (op 2) holds `busy_o` high and global bit 7 low for exactly 32 cycles. It grants blocks in ascending index order, one per cycle. A block that is locked while `wp_ni` is low gets no grant and has its bit 4 and global bit 5 set.
- R10: A request presented while `busy_o` is high is ignored: it changes no lock bit and produces no grant or deny of its own.
- R11: Asserting `rst_ni` low during erase-all stops the sequence immediately, drops `busy_o`, and clears all flags and lock bits.
- R12: `grant_erase_o` is 1 with an erase or erase-all grant and 0 with a program grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset / power-down |
| req_valid_i | input | 1 | Request strobe |
| req_op_i | input | 3 | Operation: 0 program, 1 erase, 2 erase-all, 3 lock, 4 unlock-all |
| req_blk_i | input | 5 | Target block index |
| wp_ni | input | 1 | Write protect, active low: low enforces lock bits |
| clr_status_i | input | 1 | Clear-status strobe |
| rd_blk_i | input | 5 | Block whose status byte is shown |
| grant_o | output | 1 | Operation granted (one cycle) |
| grant_erase_o | output | 1 | Granted operation is an erase |
| grant_blk_o | output | 5 | Block of the grant |
| deny_o | output | 1 | Request denied (one cycle) |
| busy_o | output | 1 | Erase-all sequence in progress |
| blk_stat_o | output | 8 | Status byte of block `rd_blk_i` |
| glb_stat_o | output | 8 | Global status byte |

## Verification
A clear-status strobe can land in the same cycle as a denied request, or as a grant that sets a block's marker bit. The bench raises `clr_status_i` together with a program to a locked block while `wp_ni` is low. It then expects the fail bits to survive while the older skip and marker bits vanish. It also checks that an erase-all walk ignores a lock request issued mid-walk, and that a reset in the middle of a walk leaves no flag or lock behind.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  typedef enum logic [2:0] {
    OP_PROG       = 3'd0,
    OP_ERASE      = 3'd1,
    OP_ERASE_ALL  = 3'd2,
    OP_LOCK       = 3'd3,
    OP_UNLOCK_ALL = 3'd4
  } blk_op_e;

  localparam int unsigned STAT_W    = 8;
  localparam int unsigned BIT_READY = 7;
  localparam int unsigned BIT_LOCK  = 6;
  localparam int unsigned BIT_FAIL  = 5;
  localparam int unsigned BIT_SKIP  = 4;
  localparam int unsigned BIT_TOUCH = 2;
endpackage

// File: rtl/blk_lock_judge.sv
module blk_lock_judge
  import blk_lock_pkg::*;
(
  input  logic    valid_i,
  input  logic    busy_i,
  input  blk_op_e op_i,
  input  logic    lock_bit_i,
  input  logic    wp_ni,
  output logic    grant_o,
  output logic    deny_o,
  output logic    set_lock_o,
  output logic    clr_locks_o,
  output logic    walk_start_o
);
  logic accept;
  logic enforce;

  assign accept  = valid_i & ~busy_i;
  assign enforce = ~wp_ni;

  always_comb begin
    grant_o      = 1'b0;
    deny_o       = 1'b0;
    set_lock_o   = 1'b0;
    clr_locks_o  = 1'b0;
    walk_start_o = 1'b0;
    if (accept) begin
      unique case (op_i)
        OP_PROG, OP_ERASE: begin
          if (enforce && lock_bit_i) deny_o  = 1'b1;
          else                       grant_o = 1'b1;
        end
        OP_ERASE_ALL: walk_start_o = 1'b1;
        OP_LOCK:      set_lock_o   = 1'b1;
        OP_UNLOCK_ALL: begin
          if (enforce) deny_o      = 1'b1;
          else         clr_locks_o = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/blk_lock_walker.sv
module blk_lock_walker #(
  parameter int unsigned NUM_BLK = 32,
  localparam int unsigned BLK_W  = $clog2(NUM_BLK)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [NUM_BLK-1:0] lock_vec_i,
  input  logic               wp_ni,
  output logic               busy_o,
  output logic               step_o,
  output logic [BLK_W-1:0]   step_idx_o,
  output logic               step_blocked_o
);
  localparam logic [BLK_W-1:0] LAST = BLK_W'(NUM_BLK - 1);

  logic             busy_q;
  logic [BLK_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (idx_q == LAST) busy_q <= 1'b0;
      else               idx_q  <= idx_q + 1'b1;
    end
  end

  assign busy_o         = busy_q;
  assign step_o         = busy_q;
  assign step_idx_o     = idx_q;
  // protection is sampled live at each step
  assign step_blocked_o = ~wp_ni & lock_vec_i[idx_q];
endmodule

// File: rtl/blk_lock_bank.sv
module blk_lock_bank
  import blk_lock_pkg::*;
#(
  parameter int unsigned NUM_BLK = 32,
  localparam int unsigned BLK_W  = $clog2(NUM_BLK)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_BLK-1:0] set_touch_i,
  input  logic [NUM_BLK-1:0] set_fail_i,
  input  logic [NUM_BLK-1:0] set_skip_i,
  input  logic [NUM_BLK-1:0] set_lock_i,
  input  logic               clr_locks_i,
  input  logic               clr_flags_i,
  input  logic [BLK_W-1:0]   rd_idx_i,
  output logic [NUM_BLK-1:0] lock_vec_o,
  output logic [STAT_W-1:0]  rd_byte_o
);
  logic [STAT_W-1:0] blk_byte [NUM_BLK];

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    logic lock_r, fail_r, skip_r, touch_r;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lock_r  <= 1'b0;
        fail_r  <= 1'b0;
        skip_r  <= 1'b0;
        touch_r <= 1'b0;
      end else begin
        if (clr_locks_i)        lock_r <= 1'b0;
        else if (set_lock_i[g]) lock_r <= 1'b1;
        // a set in the clearing cycle wins
        fail_r  <= set_fail_i[g]  | (fail_r  & ~clr_flags_i);
        skip_r  <= set_skip_i[g]  | (skip_r  & ~clr_flags_i);
        touch_r <= set_touch_i[g] | (touch_r & ~clr_flags_i);
      end
    end

    assign lock_vec_o[g] = lock_r;

    always_comb begin
      blk_byte[g]            = '0;
      blk_byte[g][BIT_LOCK]  = lock_r;
      blk_byte[g][BIT_FAIL]  = fail_r;
      blk_byte[g][BIT_SKIP]  = skip_r;
      blk_byte[g][BIT_TOUCH] = touch_r;
    end
  end

  assign rd_byte_o = blk_byte[rd_idx_i];
endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
  import blk_lock_pkg::*;
#(
  parameter int unsigned NUM_BLK = 32,
  localparam int unsigned BLK_W  = $clog2(NUM_BLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [2:0]        req_op_i,
  input  logic [BLK_W-1:0]  req_blk_i,
  input  logic              wp_ni,
  input  logic              clr_status_i,
  input  logic [BLK_W-1:0]  rd_blk_i,
  output logic              grant_o,
  output logic              grant_erase_o,
  output logic [BLK_W-1:0]  grant_blk_o,
  output logic              deny_o,
  output logic              busy_o,
  output logic [STAT_W-1:0] blk_stat_o,
  output logic [STAT_W-1:0] glb_stat_o
);
  blk_op_e            op;
  logic [NUM_BLK-1:0] lock_vec;
  logic               busy;
  logic               j_grant, j_deny, j_set_lock, j_clr_locks, j_walk;
  logic               w_step, w_blocked;
  logic [BLK_W-1:0]   w_idx;

  logic               evt_grant, evt_skip, evt_fail_glb, evt_erase;
  logic [BLK_W-1:0]   evt_blk;
  logic [NUM_BLK-1:0] evt_onehot;
  logic [NUM_BLK-1:0] set_touch, set_fail, set_skip, set_lock;

  logic               grant_q, erase_q, deny_q, glb_fail_q;
  logic [BLK_W-1:0]   blk_q;

  assign op = blk_op_e'(req_op_i);

  blk_lock_judge u_judge (
    .valid_i     (req_valid_i),
    .busy_i      (busy),
    .op_i        (op),
    .lock_bit_i  (lock_vec[req_blk_i]),
    .wp_ni       (wp_ni),
    .grant_o     (j_grant),
    .deny_o      (j_deny),
    .set_lock_o  (j_set_lock),
    .clr_locks_o (j_clr_locks),
    .walk_start_o(j_walk)
  );

  blk_lock_walker #(.NUM_BLK(NUM_BLK)) u_walk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .start_i       (j_walk),
    .lock_vec_i    (lock_vec),
    .wp_ni         (wp_ni),
    .busy_o        (busy),
    .step_o        (w_step),
    .step_idx_o    (w_idx),
    .step_blocked_o(w_blocked)
  );

  // single requests are only accepted while idle, so the two sources never overlap
  always_comb begin
    evt_blk      = busy ? w_idx : req_blk_i;
    evt_grant    = j_grant | (w_step & ~w_blocked);
    evt_skip     = w_step & w_blocked;
    evt_erase    = busy | (op == OP_ERASE);
    evt_fail_glb = j_deny | evt_skip;
    evt_onehot   = '0;
    evt_onehot[evt_blk] = 1'b1;
    set_touch    = evt_grant ? evt_onehot : '0;
    set_skip     = evt_skip  ? evt_onehot : '0;
    set_fail     = (j_deny && !busy && (op == OP_PROG || op == OP_ERASE)) ? evt_onehot : '0;
    set_lock     = j_set_lock ? evt_onehot : '0;
  end

  blk_lock_bank #(.NUM_BLK(NUM_BLK)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_touch_i(set_touch),
    .set_fail_i (set_fail),
    .set_skip_i (set_skip),
    .set_lock_i (set_lock),
    .clr_locks_i(j_clr_locks),
    .clr_flags_i(clr_status_i),
    .rd_idx_i   (rd_blk_i),
    .lock_vec_o (lock_vec),
    .rd_byte_o  (blk_stat_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_q    <= 1'b0;
      erase_q    <= 1'b0;
      deny_q     <= 1'b0;
      blk_q      <= '0;
      glb_fail_q <= 1'b0;
    end else begin
      grant_q    <= evt_grant;
      erase_q    <= evt_grant & evt_erase;
      deny_q     <= j_deny;
      if (evt_grant) blk_q <= evt_blk;
      glb_fail_q <= evt_fail_glb | (glb_fail_q & ~clr_status_i);
    end
  end

  always_comb begin
    glb_stat_o            = '0;
    glb_stat_o[BIT_READY] = ~busy;
    glb_stat_o[BIT_FAIL]  = glb_fail_q;
  end

  assign grant_o       = grant_q;
  assign grant_erase_o = erase_q;
  assign grant_blk_o   = blk_q;
  assign deny_o        = deny_q;
  assign busy_o        = busy;
endmodule

// File: rtl/blk_lock_chk.sv
module blk_lock_chk #(
  parameter int unsigned NUM_BLK = 32,
  localparam int unsigned BLK_W  = $clog2(NUM_BLK)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [2:0]         req_op_i,
  input logic [BLK_W-1:0]   req_blk_i,
  input logic               wp_ni,
  input logic               clr_status_i,
  input logic               grant_o,
  input logic [BLK_W-1:0]   grant_blk_o,
  input logic               deny_o,
  input logic               busy_o,
  input logic [7:0]         glb_stat_o,
  input logic [NUM_BLK-1:0] lock_vec_i
);
  logic [NUM_BLK-1:0] lock_prev;
  logic               wp_prev;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock_prev <= '0;
      wp_prev   <= 1'b1;
    end else begin
      lock_prev <= lock_vec_i;
      wp_prev   <= wp_ni;
    end
  end

  assert_no_grant_locked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (wp_prev || !lock_prev[grant_blk_o]));

  assert_grant_deny_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(grant_o && deny_o));

  assert_deny_flag_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    deny_o |-> glb_stat_o[5]);

  assert_lock_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_status_i && !(req_valid_i && !busy_o)) |=> $stable(lock_vec_i));

  assert_clear_glb_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_status_i && !req_valid_i && !busy_o) |=> !glb_stat_o[5]);

  assert_walk_start_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o && req_op_i == 3'd2) |=> busy_o);

  assert_busy_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_valid_i && req_op_i == 3'd3 && !lock_vec_i[req_blk_i])
      |=> !lock_vec_i[$past(req_blk_i)]);
endmodule

bind blk_lock_ctrl blk_lock_chk #(.NUM_BLK(NUM_BLK)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_op_i    (req_op_i),
  .req_blk_i   (req_blk_i),
  .wp_ni       (wp_ni),
  .clr_status_i(clr_status_i),
  .grant_o     (grant_o),
  .grant_blk_o (grant_blk_o),
  .deny_o      (deny_o),
  .busy_o      (busy_o),
  .glb_stat_o  (glb_stat_o),
  .lock_vec_i  (lock_vec)
);

// File: tb/sim_blk_lock_ctrl.sv
module sim_blk_lock_ctrl;
  localparam int NB = 32;
  localparam logic [2:0] P = 3'd0, E = 3'd1, EA = 3'd2, L = 3'd3, UA = 3'd4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       valid = 1'b0;
  logic [2:0] op = 3'd0;
  logic [4:0] blk = '0;
  logic       wp_n = 1'b1;
  logic       clr = 1'b0;
  logic [4:0] rd_blk = '0;
  logic       grant, grant_erase, deny, busy;
  logic [4:0] grant_blk;
  logic [7:0] blk_stat, glb_stat;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  blk_lock_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(valid), .req_op_i(op),
    .req_blk_i(blk), .wp_ni(wp_n), .clr_status_i(clr), .rd_blk_i(rd_blk),
    .grant_o(grant), .grant_erase_o(grant_erase), .grant_blk_o(grant_blk),
    .deny_o(deny), .busy_o(busy), .blk_stat_o(blk_stat), .glb_stat_o(glb_stat)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // {valid, op, blk, wp_n, clr, exp_grant, exp_deny, exp_stat}
  function automatic logic [20:0] mkv(logic v, logic [2:0] o, logic [4:0] b, logic w,
                                      logic c, logic g, logic d, logic [7:0] s);
    return {v, o, b, w, c, g, d, s};
  endfunction

  localparam int NV = 13;
  localparam logic [20:0] TBL [NV] = '{
    mkv(1, P,  5'd3,  1, 0, 1, 0, 8'h04),
    mkv(1, L,  5'd3,  1, 0, 0, 0, 8'h44),
    mkv(1, P,  5'd3,  1, 0, 1, 0, 8'h44),
    mkv(1, E,  5'd3,  0, 0, 0, 1, 8'h64),
    mkv(0, P,  5'd3,  0, 1, 0, 0, 8'h40),
    mkv(1, P,  5'd7,  0, 0, 1, 0, 8'h04),
    mkv(1, L,  5'd31, 0, 0, 0, 0, 8'h40),
    mkv(1, E,  5'd31, 0, 0, 0, 1, 8'h60),
    mkv(1, E,  5'd0,  0, 0, 1, 0, 8'h04),
    mkv(1, UA, 5'd31, 0, 0, 0, 1, 8'h60),
    mkv(1, UA, 5'd31, 1, 0, 0, 0, 8'h20),
    mkv(1, P,  5'd31, 0, 1, 1, 0, 8'h04),
    mkv(0, P,  5'd3,  0, 0, 0, 0, 8'h00)
  };
  localparam string TAG [NV] = '{
    "R4 program unlocked", "R5 lock set", "R4 wp high overrides lock",
    "R3 locked erase denied", "R6 clear keeps lock", "R4 wp low unlocked",
    "R5 lock with wp low", "R3 denied fail bit", "R2 touch bit",
    "R8 unlock refused", "R8 unlock applied", "R7 set beats clear",
    "R8 locks gone"
  };

  task automatic drive(input logic v, input logic [2:0] o, input logic [4:0] b,
                       input logic w, input logic c);
    @(negedge clk);
    valid = v; op = o; blk = b; wp_n = w; clr = c; rd_blk = b;
  endtask

  task automatic idle();
    @(negedge clk);
    valid = 1'b0; clr = 1'b0;
  endtask

  task automatic walk(input logic w, input logic lock_mid, output int grants,
                      output int order_err);
    grants = 0; order_err = 0;
    drive(1, EA, 5'd0, w, 0);
    @(posedge clk); #1;
    chk("R9 busy after start", busy, 1);
    chk("R9 ready bit low", glb_stat[7], 0);
    for (int k = 0; k < NB; k++) begin
      @(negedge clk);
      if (k == 0 && lock_mid) begin valid = 1'b1; op = L; blk = 5'd10; end
      else valid = 1'b0;
      @(posedge clk); #1;
      if (grant) begin
        grants++;
        if (grant_blk != 5'(k) || !grant_erase) order_err++;
      end
    end
    chk("R9 busy ends after 32 steps", busy, 0);
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int g, oe;
    repeat (3) @(negedge clk);
    chk("R1 grant at reset", grant, 0);
    chk("R1 busy at reset", busy, 0);
    chk("R1 glb at reset", glb_stat, 8'h80);
    rd_blk = 5'd17; #1;
    chk("R1 block at reset", blk_stat, 8'h00);
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i][20], TBL[i][19:17], TBL[i][16:12], TBL[i][11], TBL[i][10]);
      @(posedge clk); #1;
      chk(TAG[i], grant, int'(TBL[i][9]));
      chk(TAG[i], deny,  int'(TBL[i][8]));
      chk(TAG[i], blk_stat, int'(TBL[i][7:0]));
    end
    idle();

    // R12 erase vs program grant kind
    drive(1, E, 5'd9, 0, 0);
    @(posedge clk); #1;
    chk("R12 erase grant", {grant, grant_erase}, 2'b11);
    drive(1, P, 5'd9, 0, 0);
    @(posedge clk); #1;
    chk("R12 program grant", {grant, grant_erase}, 2'b10);

    // erase-all with protection enforced, lock request mid-walk
    drive(0, P, 5'd0, 0, 1);
    drive(1, L, 5'd2, 0, 0);
    drive(1, L, 5'd5, 0, 0);
    idle();
    walk(1'b0, 1'b1, g, oe);
    chk("R9 grants with two locked", g, NB - 2);
    chk("R9 ascending order", oe, 0);
    chk("R9 glb fail after skip", glb_stat, 8'hA0);
    rd_blk = 5'd2; #1;
    chk("R9 skip bit", blk_stat, 8'h50);
    rd_blk = 5'd10; #1;
    chk("R10 lock ignored while busy", blk_stat, 8'h04);

    // erase-all with protection released
    drive(0, P, 5'd0, 1, 1);
    idle();
    walk(1'b1, 1'b0, g, oe);
    chk("R4 all granted wp high", g, NB);
    chk("R4 walk order wp high", oe, 0);
    rd_blk = 5'd5; #1;
    chk("R4 locked block touched", blk_stat, 8'h44);

    // R7 deny in the clearing cycle
    drive(1, P, 5'd5, 0, 1);
    @(posedge clk); #1;
    chk("R7 deny with clear", deny, 1);
    chk("R7 block flags", blk_stat, 8'h60);
    chk("R7 glb fail kept", glb_stat, 8'hA0);
    drive(0, P, 5'd5, 0, 1);
    @(posedge clk); #1;
    chk("R6 clear flags", blk_stat, 8'h40);
    chk("R6 clear glb", glb_stat, 8'h80);
    idle();

    // R11 reset during walk
    drive(1, EA, 5'd0, 0, 0);
    idle();
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b0; rd_blk = 5'd5; #1;
    chk("R11 busy dropped", busy, 0);
    chk("R11 glb cleared", glb_stat, 8'h80);
    chk("R11 lock cleared", blk_stat, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R11 no grant after reset", grant, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule